// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This block watches the load and store traffic on a core's data memory port and stops an access before it reaches memory when its address falls inside a watched region. It holds one or two independent channels. Each channel has a breakpoint address register and a control register, and both are written through a small special-register write port.

The control register arms the channel for loads, for stores, or for both. It also carries a six-bit compare-keep field that sets the size of the watched window, as a power of two from 1 to 64 bytes. Field bits that are set compare the matching address bit. Every address bit above the field is always compared. If software writes a field with a hole in it, the hardware keeps only the unbroken run of ones that starts at the top of the field. The window then follows from that run and is aligned down from the programmed address.

On a match, the unit raises a debug request and reports a bitmap of the matching channels and the lowest-numbered one, which the debug logic uses as the cause. It also withholds the enable that lets the access proceed to memory, all in the same cycle.

Top module: `dwatch_unit`

## Requirements
- R1: Control bit 7 (store enable) arms a channel for store accesses (`acc_store`=1). A channel with bits 7 and 6 both clear never matches.
- R2: Control bit 6 (load enable) arms a channel for load accesses (`acc_store`=0). A channel armed only for stores ignores loads, and a channel armed only for loads ignores stores.
- R3: The effective compare mask has ones in every bit above 5 and the field from control bits [5:0] in bits [5:0]. A channel matches when the access address equals the breakpoint address in every bit where this mask is 1. Field 6'b111111 watches 1 byte, 6'b111000 watches 8 bytes and 6'b000000 watches 64 bytes.
- R4: A field that is not a contiguous run of ones from bit 5 downward is reduced to the ones above its highest zero bit. For example, 6'b110100 acts as 6'b110000, a 16-byte window aligned down from the breakpoint address.
- R5: While any channel matches a valid access, `mem_en` is 0, so the load returns nothing and the store does not write. Otherwise `mem_en` follows `acc_valid`.
- R6: `hit_vec` bit c is 1 exactly when channel c matches a valid access. `dbg_req` is the OR of `hit_vec`, and `hit_first` is the lowest index whose bit is set. With no valid access, nothing matches.
- R7: A register write on the write port is sampled at a rising clock edge and first affects accesses in the cycle after that edge. An access in the same cycle as the write is compared against the old value.
- R8: Reset clears the control registers and the address registers of every channel, so no channel matches after reset.
- R9: A write goes to channel `sr_ch`. It updates the control register when `sr_ctrl`=1 and the address register when `sr_ctrl`=0, and leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_we | input | 1 | Register write strobe |
| sr_ch | input | CH_W (1) | Channel selected by the write |
| sr_ctrl | input | 1 | 1 selects the control register, 0 the address register |
| sr_wdata | input | ADDR_W (32) | Write data |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W (32) | Byte address of the access |
| mem_en | output | 1 | Access may proceed to memory |
| dbg_req | output | 1 | Debug request, raised on any match |
| hit_vec | output | NUM_CH (2) | Bitmap of matching channels |
| hit_first | output | CH_W (1) | Lowest matching channel index |

## Verification
On every cycle, the assertions check the following. The reduced compare mask is always a contiguous power-of-two window, and it equals the raw field whenever that field is already contiguous. A disarmed channel never matches, and a matching access never reaches memory. The reported lowest channel is set in the bitmap with no lower bit beside it, and a control write is visible one cycle later. Only the bench scenarios show that window edges are placed correctly, that higher address bits are compared, and that loads and stores are told apart per channel. They also show that overlapping channels report together and that an access in the same cycle as a write still sees the old setting.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
   // Offsets of the arm bits relative to the top of the compare-keep field
   localparam int unsigned LD_OFS = 0;
   localparam int unsigned ST_OFS = 1;

   typedef struct packed {
      logic st_en;
      logic ld_en;
   } arm_t;

   // true when the access kind is armed on a channel
   function automatic logic kind_armed(input arm_t arm, input logic is_store);
      return is_store ? arm.st_en : arm.ld_en;
   endfunction
endpackage

// File: rtl/dbw_mask_fix.sv
module dbw_mask_fix #(
   parameter int unsigned FIELD_W = 6
) (
   input  logic [FIELD_W-1:0] fld_i,
   output logic [FIELD_W-1:0] fld_o
);
   // running AND from the top bit: stops at the first zero seen
   logic [FIELD_W:0] run;
   assign run[FIELD_W] = 1'b1;

   for (genvar i = FIELD_W - 1; i >= 0; i--) begin : g_run
      assign run[i] = run[i+1] & fld_i[i];
   end

   assign fld_o = run[FIELD_W-1:0];
endmodule

// File: rtl/dbw_channel.sv
module dbw_channel
   import dbw_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned FIELD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr_en,
   input  logic              wr_ctrl_en,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              acc_valid,
   input  logic              acc_store,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              hit
);
   localparam int unsigned CTRL_W = FIELD_W + 2;
   localparam int unsigned HI_W   = ADDR_W - FIELD_W;

   logic [ADDR_W-1:0]  bp_addr_q;
   logic [CTRL_W-1:0]  ctrl_q;
   logic [FIELD_W-1:0] fld_fix;
   logic [ADDR_W-1:0]  eff_mask;
   logic [ADDR_W-1:0]  raw_mask;
   arm_t               arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_addr_q <= '0;
         ctrl_q    <= '0;
      end else begin
         if (wr_addr_en) bp_addr_q <= wdata;
         if (wr_ctrl_en) ctrl_q    <= wdata[CTRL_W-1:0];
      end
   end

   dbw_mask_fix #(.FIELD_W(FIELD_W)) u_fix (
      .fld_i (ctrl_q[FIELD_W-1:0]),
      .fld_o (fld_fix)
   );

   assign arm.ld_en = ctrl_q[FIELD_W+LD_OFS];
   assign arm.st_en = ctrl_q[FIELD_W+ST_OFS];
   assign raw_mask  = {{HI_W{1'b1}}, ctrl_q[FIELD_W-1:0]};
   assign eff_mask  = {{HI_W{1'b1}}, fld_fix};

   always_comb begin
      hit = acc_valid && kind_armed(arm, acc_store)
            && (((acc_addr ^ bp_addr_q) & eff_mask) == '0);
   end

   // R4: reduced mask is always one contiguous power-of-two window
   a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (((~eff_mask) + ADDR_W'(1)) & (~eff_mask)) == '0);

   // R4: an already contiguous field passes unchanged
   a_r4_keep_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ((((~raw_mask) + ADDR_W'(1)) & (~raw_mask)) == '0) |-> (eff_mask == raw_mask));

   // R1: with neither arm bit the channel stays silent
   a_r1_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[FIELD_W+1:FIELD_W] == 2'b00) |-> !hit);

   // R7: a control write is seen in the following cycle
   a_r7_ctrl_next: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl_en |=> (ctrl_q == $past(wdata[CTRL_W-1:0])));

   // R8: leaving reset with control cleared
   a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctrl_q == '0));
endmodule

// File: rtl/dbw_prio.sv
module dbw_prio #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned CH_W   = 1
) (
   input  logic [NUM_CH-1:0] hits,
   output logic              any,
   output logic [CH_W-1:0]   first
);
   always_comb begin
      first = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (hits[i]) first = CH_W'(i);
      end
      any = |hits;
   end
endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit #(
   parameter int unsigned NUM_CH  = 2,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned FIELD_W = 6,
   parameter int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sr_we,
   input  logic [CH_W-1:0]   sr_ch,
   input  logic              sr_ctrl,
   input  logic [ADDR_W-1:0] sr_wdata,
   input  logic              acc_valid,
   input  logic              acc_store,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              mem_en,
   output logic              dbg_req,
   output logic [NUM_CH-1:0] hit_vec,
   output logic [CH_W-1:0]   hit_first
);
   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("dwatch_unit: NUM_CH must be 1 or 2");
   end
   if (FIELD_W < 1 || FIELD_W + 2 > ADDR_W) begin : g_bad_field
      $error("dwatch_unit: FIELD_W out of range for ADDR_W");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel;
      assign sel = sr_we && (sr_ch == CH_W'(c));

      dbw_channel #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_addr_en (sel && !sr_ctrl),
         .wr_ctrl_en (sel && sr_ctrl),
         .wdata      (sr_wdata),
         .acc_valid  (acc_valid),
         .acc_store  (acc_store),
         .acc_addr   (acc_addr),
         .hit        (hit_vec[c])
      );
   end

   dbw_prio #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_prio (
      .hits  (hit_vec),
      .any   (dbg_req),
      .first (hit_first)
   );

   assign mem_en = acc_valid && !dbg_req;

   // R5: a matched access never reaches memory
   a_r5_block: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(hit_vec) > 0) |-> !mem_en);

   // R6: reported channel is set in the bitmap
   a_r6_first_set: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |-> (((hit_vec >> hit_first) & NUM_CH'(1)) != '0));

   // R6: no lower channel is set below the reported one
   a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |-> ((hit_vec & ((NUM_CH'(1) << hit_first) - NUM_CH'(1))) == '0));

   // R6: no valid access, no match
   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (hit_vec == '0));
endmodule

// File: tb/sim_dwatch_unit.sv
module sim_dwatch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sr_we = 1'b0;
   logic [0:0]  sr_ch = '0;
   logic        sr_ctrl = 1'b0;
   logic [31:0] sr_wdata = '0;
   logic        acc_valid = 1'b0;
   logic        acc_store = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        mem_en, dbg_req;
   logic [1:0]  hit_vec;
   logic [0:0]  hit_first;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dwatch_unit u0 (
      .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_ch(sr_ch), .sr_ctrl(sr_ctrl),
      .sr_wdata(sr_wdata), .acc_valid(acc_valid), .acc_store(acc_store),
      .acc_addr(acc_addr), .mem_en(mem_en), .dbg_req(dbg_req),
      .hit_vec(hit_vec), .hit_first(hit_first)
   );

   localparam int NV = 10;
   localparam logic        V_ST  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam logic [31:0] V_AD  [NV] = '{32'h1000_0040, 32'h1000_0047, 32'h1000_0048,
                                         32'h1000_003F, 32'h2000_0010, 32'h2000_001F,
                                         32'h2000_0015, 32'h2000_0020, 32'h2000_000F,
                                         32'h3000_0040};
   localparam logic [1:0]  V_HIT [NV] = '{2'b01, 2'b01, 2'b00, 2'b00, 2'b10, 2'b10,
                                         2'b00, 2'b00, 2'b00, 2'b00};

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic ch, input logic ctrl, input logic [31:0] d);
      @(negedge clk);
      sr_we = 1'b1; sr_ch = ch; sr_ctrl = ctrl; sr_wdata = d;
      @(posedge clk);
      #1 sr_we = 1'b0;
   endtask

   task automatic acc(input logic st, input logic [31:0] a);
      @(negedge clk);
      acc_valid = 1'b1; acc_store = st; acc_addr = a;
      #1;
   endtask

   task automatic chk_hit(input string req, input logic [1:0] exp);
      chk(req, {30'b0, hit_vec}, {30'b0, exp});
      chk({req, " dbg_req"}, {31'b0, dbg_req}, {31'b0, |exp});
      chk({req, " mem_en"}, {31'b0, mem_en}, {31'b0, acc_valid && (exp == 2'b00)});
      if (exp != 2'b00)
         chk({req, " hit_first"}, {31'b0, hit_first}, {31'b0, ~exp[0]});
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R8: after reset nothing is armed, even at address 0
      acc(1'b0, 32'h0);   chk_hit("R8 reset load", 2'b00);
      acc(1'b1, 32'h0);   chk_hit("R8 reset store", 2'b00);

      // R9: program both channels
      wr(1'b0, 1'b0, 32'h1000_0043);
      wr(1'b0, 1'b1, 32'h0000_00F8);   // load+store, 8 bytes
      wr(1'b1, 1'b0, 32'h2000_0013);
      wr(1'b1, 1'b1, 32'h0000_00B4);   // store only, field 110100 -> 16 bytes

      // R1 R2 R3 R4 R5 R6: vector table
      for (int i = 0; i < NV; i++) begin
         acc(V_ST[i], V_AD[i]);
         chk_hit($sformatf("R3 R4 vec%0d", i), V_HIT[i]);
      end

      // R6: no valid access, no match
      @(negedge clk); acc_valid = 1'b0; acc_addr = 32'h1000_0040; #1;
      chk_hit("R6 idle", 2'b00);

      // R9 R6: channel 1 becomes a 1-byte load watch overlapping channel 0
      wr(1'b1, 1'b0, 32'h1000_0044);
      wr(1'b1, 1'b1, 32'h0000_007F);
      acc(1'b0, 32'h1000_0044); chk_hit("R6 overlap", 2'b11);
      acc(1'b0, 32'h1000_0045); chk_hit("R3 one byte", 2'b01);
      acc(1'b1, 32'h1000_0044); chk_hit("R2 load-only ignores store", 2'b01);

      // R7: same-cycle write sees old value, next cycle sees new
      @(negedge clk);
      acc_valid = 1'b1; acc_store = 1'b0; acc_addr = 32'h1000_0040;
      sr_we = 1'b1; sr_ch = 1'b0; sr_ctrl = 1'b1; sr_wdata = 32'h0000_0038;
      #1 chk_hit("R7 old value", 2'b01);
      @(posedge clk); #1 sr_we = 1'b0;
      chk_hit("R7 new value", 2'b00);
      // R1: unarmed channel never matches
      acc(1'b1, 32'h1000_0040); chk_hit("R1 unarmed store", 2'b00);

      // R3: 64-byte window from field 000000
      wr(1'b0, 1'b0, 32'h5000_0021);
      wr(1'b0, 1'b1, 32'h0000_0040);
      acc(1'b0, 32'h5000_0000); chk_hit("R3 64B low", 2'b01);
      acc(1'b0, 32'h5000_003F); chk_hit("R3 64B high", 2'b01);
      acc(1'b0, 32'h5000_0040); chk_hit("R3 64B outside", 2'b00);

      // R9: channel 0 write left channel 1 untouched
      acc(1'b0, 32'h1000_0044); chk_hit("R9 other channel kept", 2'b10);

      @(negedge clk); acc_valid = 1'b0;
      finish_run();
   end
endmodule